// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous control front end of a pipelined, common-IO burst SRAM with its own storage array. Every control input is captured on the rising clock edge: the address, three chip enables, a processor-side and a controller-side address strobe, the advance input, a global write, a byte write enable and four per-lane byte selects. From these it decides at each edge whether the cycle is a read, a write, a deselect or nothing. It then masks writes per byte lane, returns read data through an output register and controls whether the data-out port is driven.

The two strobes behave differently. The processor strobe has priority, always opens with a read and can write only on the following clock. The controller strobe can write on the same edge. After an access opens, cycles with no strobe continue it. In these cycles the chip enables are not sampled again, and the address is either held or taken from an external burst sequencer. The data-out enable combines a registered drive condition with an asynchronous, active-low output enable.

Top module: `sram_burst_ctrl`

## Requirements
- R1: An access starts at an edge only when a recognised strobe is low and `cs1_n` is low, `cs2` is high and `cs3_n` is low. A recognised strobe edge with any chip enable inactive deselects the block. While the block is deselected and no strobe is low, no write takes place.
- R2: When both strobes are low, only `pstb_n` is recognised. `pstb_n` is ignored entirely while `cs1_n` is high.
- R3: A `pstb_n` start is a read at `addr`, whatever the write controls and `adv_n` are. If write controls are active at the next edge with no strobe, that edge writes, so this write takes two clocks.
- R4: A `cstb_n` start with `pstb_n` not recognised is a write at `addr` on that same edge when write controls are active, and a read otherwise. `adv_n` is ignored on that edge.
- R5: Lane L is bits [9L+8:9L] of `din`. When `gwr_n` is low, all four lanes are written. Otherwise lane L is written only when `bwen_n` is low and `bsel_n[L]` is low. Lanes that are not written keep their old value.
- R6: For a read registered at edge N, `dout` holds that address's data after edge N+1, with `dout_en` high when the drive conditions allow it.
- R7: `dout_en` is low in the cycle after the read edge that leaves the deselected state. In the cycles that follow, `dout_en` follows `oe_n` (active low) without waiting for a clock.
- R8: `dout_en` is low in the cycle after any write edge and after any deselecting strobe edge, whatever `oe_n` is.
- R9: At an edge with no strobe while the block is selected, the access continues. The address is `burst_addr` when `adv_n` is low and is held when `adv_n` is high. The cycle is a write if write controls are active and a read otherwise. The chip enables are ignored at this edge.
- R10: While `rst_n` is low and after it is released, the block is deselected and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | External address, loaded on a strobe |
| burst_addr | input | ADDR_W | Next address from the burst sequencer |
| cs1_n | input | 1 | Chip enable 1, active low; also qualifies the processor strobe |
| cs2 | input | 1 | Chip enable 2, active high |
| cs3_n | input | 1 | Chip enable 3, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance to burst address, active low |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The main collision is a read and a write on consecutive edges of one access. This happens when a processor-strobe read is followed by a write on the next clock. The output register then loads the read result on the same edge that the write cycle suppresses the drive. The bench builds this case and expects `dout_en` low, then reads the address back to confirm the write landed. A second case sets both strobes low together with the write controls active. The expected result is that no write takes place and the edge counts as a read, so the data from that address is driven one cycle later.

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ADDR_W-1:0]         burst_addr,
  input  logic                      cs1_n,
  input  logic                      cs2,
  input  logic                      cs3_n,
  input  logic                      pstb_n,
  input  logic                      cstb_n,
  input  logic                      adv_n,
  input  logic                      gwr_n,
  input  logic                      bwen_n,
  input  logic [LANES-1:0]          bsel_n,
  input  logic                      oe_n,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              active_q, rd_pend_q, drive_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q;

  wire sel    = !cs1_n && cs2 && !cs3_n;
  wire p_go   = !pstb_n && !cs1_n;
  wire c_go   = !cstb_n && !p_go;
  wire strobe = p_go || c_go;
  wire cont   = !strobe && active_q;
  wire desel  = strobe && !sel;

  wire [LANES-1:0] lane_wr = !gwr_n ? {LANES{1'b1}} : (!bwen_n ? ~bsel_n : {LANES{1'b0}});
  wire wr_ctl = |lane_wr;

  wire do_wr = (c_go && sel && wr_ctl) || (cont && wr_ctl);
  wire do_rd = (p_go && sel) || (c_go && sel && !wr_ctl) || (cont && !wr_ctl);

  wire [ADDR_W-1:0] cur_addr = strobe ? addr : (adv_n ? addr_q : burst_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      rd_pend_q <= 1'b0;
      drive_q   <= 1'b0;
      addr_q    <= '0;
      dout_q    <= '0;
    end else begin
      if (strobe) active_q <= sel;
      if (do_rd || do_wr) addr_q <= cur_addr;
      rd_pend_q <= do_rd;
      drive_q   <= rd_pend_q && !do_wr && !desel;
      if (rd_pend_q) dout_q <= mem[addr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && do_wr) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_wr[l]) mem[cur_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
      end
    end
  end

  assign dout    = dout_q;
  assign dout_en = drive_q && !oe_n;
endmodule

// File: rtl/sram_burst_ctrl_chk.sv
module sram_burst_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pstb_n,
  input logic cstb_n,
  input logic cs1_n,
  input logic cs2,
  input logic cs3_n,
  input logic gwr_n,
  input logic bwen_n,
  input logic oe_n,
  input logic dout_en
);
  wire sel = !cs1_n && cs2 && !cs3_n;

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en); // R7

  AST_FIRST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstb_n && cs1_n) ##1 (!pstb_n && sel) |=> !dout_en); // R7

  AST_WRITE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstb_n && pstb_n && sel && !gwr_n) |=> !dout_en); // R8

  AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstb_n && cs1_n) |=> !dout_en); // R8

  AST_PROC_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && !cstb_n && sel && !gwr_n) ##1 (pstb_n && cstb_n && gwr_n && bwen_n)
      |=> (dout_en == !oe_n)); // R2
endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pstb_n(pstb_n), .cstb_n(cstb_n),
  .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .gwr_n(gwr_n),
  .bwen_n(bwen_n), .oe_n(oe_n), .dout_en(dout_en)
);

// File: tb/sram_burst_ctrl_tb.sv
`timescale 1ns/1ps
module sram_burst_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, burst = 0;
  logic cs1_n = 1, cs2 = 0, cs3_n = 1, pstb_n = 1, cstb_n = 1, adv_n = 1;
  logic gwr_n = 1, bwen_n = 1, oe_n = 0;
  logic [3:0] bsel_n = 4'hF;
  logic [35:0] din = 0, dout;
  logic dout_en;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sram_burst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .burst_addr(burst),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .adv_n(adv_n), .gwr_n(gwr_n), .bwen_n(bwen_n), .bsel_n(bsel_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  logic [35:0] mm [int];
  int rdq[$];
  bit m_act = 0, exp_drv = 0, exp_known = 0;
  int m_addr = 0;
  logic [35:0] exp_data = 0;

  task automatic model_edge();
    bit sel, pgo, cgo, had;
    int kind, a, ra;
    bit [3:0] lanes;
    if (!rst_n) begin
      m_act = 0; rdq.delete(); exp_drv = 0; return;
    end
    sel = !cs1_n && cs2 && !cs3_n;
    pgo = !pstb_n && !cs1_n;
    cgo = !cstb_n && !pgo;
    lanes = !gwr_n ? 4'hF : (!bwen_n ? ~bsel_n : 4'h0);
    kind = 0; a = m_addr;
    if (pgo || cgo) begin
      a = addr;
      if (!sel) kind = 3;
      else if (pgo) kind = 1;
      else kind = (lanes != 0) ? 2 : 1;
    end else if (m_act) begin
      a = adv_n ? m_addr : int'(burst);
      kind = (lanes != 0) ? 2 : 1;
    end
    had = rdq.size() > 0;
    if (had) begin
      ra = rdq.pop_front();
      exp_known = mm.exists(ra);
      if (exp_known) exp_data = mm[ra];
    end
    exp_drv = had && kind != 2 && kind != 3;
    if (kind == 2) begin
      logic [35:0] v;
      v = mm.exists(a) ? mm[a] : 36'h0;
      for (int l = 0; l < 4; l++) if (lanes[l]) v[l*9 +: 9] = din[l*9 +: 9];
      mm[a] = v;
    end
    if (kind == 1) rdq.push_back(a);
    if (kind == 1 || kind == 2) m_addr = a;
    if (pgo || cgo) m_act = sel;
  endtask

  task automatic compare(input string tag);
    bit ee;
    ee = exp_drv && !oe_n;
    checks++;
    if (dout_en !== ee) begin
      fails++; $display("FAIL %s dout_en actual=%0b expected=%0b", tag, dout_en, ee);
    end
    if (ee && exp_known) begin
      checks++;
      if (dout !== exp_data) begin
        fails++; $display("FAIL %s dout actual=%h expected=%h", tag, dout, exp_data);
      end
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk); model_edge();
    @(negedge clk); compare(tag);
  endtask

  task automatic rest();
    pstb_n = 1; cstb_n = 1; adv_n = 1; gwr_n = 1; bwen_n = 1; bsel_n = 4'hF;
  endtask
  task automatic sel_on();  cs1_n = 0; cs2 = 1; cs3_n = 0; endtask

  initial begin
    #(8ns * 200000);
    fails++; $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick("R10"); tick("R10");
    rst_n = 1; tick("R10");
    // R4: controller-strobe global writes fill addresses 0..7
    for (int i = 0; i < 8; i++) begin
      rest(); sel_on(); cstb_n = 0; gwr_n = 0; adv_n = 0; burst = 8'hEE;
      addr = i[7:0]; din = {4{i[8:0] + 9'h41}}; tick("R4");
    end
    // R8: deselect via controller strobe with cs1_n high
    rest(); cs1_n = 1; cstb_n = 0; addr = 8'h55; tick("R8");
    // R7: processor read leaving deselect, first cycle quiet
    rest(); sel_on(); pstb_n = 0; addr = 3; tick("R7");
    // R9/R6: hold address, then burst advance
    rest(); cs2 = 0; tick("R9");
    rest(); adv_n = 0; burst = 4; tick("R6");
    rest(); adv_n = 0; burst = 5; tick("R9");
    rest(); tick("R6");
    // R7: asynchronous output enable
    oe_n = 1; #1; checks++;
    if (dout_en !== 1'b0) begin fails++; $display("FAIL R7 dout_en actual=%0b expected=0", dout_en); end
    oe_n = 0; #1; checks++;
    if (dout_en !== 1'b1) begin fails++; $display("FAIL R7 dout_en actual=%0b expected=1", dout_en); end
    // R3: processor start ignores write controls, then two-clock write
    rest(); sel_on(); pstb_n = 0; gwr_n = 0; adv_n = 0; addr = 10; din = 36'hAAAAAAAAA; tick("R3");
    rest(); gwr_n = 0; din = 36'h123456789; tick("R8");
    rest(); tick("R3");
    rest(); tick("R3");
    // R5: byte write lanes 0 and 2 onto address 2
    rest(); cstb_n = 0; bwen_n = 0; bsel_n = 4'b1010; addr = 2; din = 36'h1FF_1FF_1FF; din = {9'h0F0, 9'h0F1, 9'h0F2, 9'h0F3}; tick("R5");
    rest(); bwen_n = 1; bsel_n = 4'b0000; tick("R5");
    rest(); cstb_n = 0; addr = 2; tick("R5");
    rest(); tick("R5");
    rest(); tick("R5");
    // R2: both strobes low with write: read wins
    rest(); pstb_n = 0; cstb_n = 0; gwr_n = 0; addr = 6; din = 36'h0; tick("R2");
    rest(); tick("R2");
    rest(); tick("R2");
    // R2: processor strobe ignored when cs1_n high (continuation)
    rest(); cs1_n = 1; pstb_n = 0; addr = 1; tick("R2");
    rest(); sel_on(); tick("R2");
    // R1: cs2 low deselects; writes without strobe do nothing
    rest(); cs2 = 0; cstb_n = 0; addr = 0; tick("R1");
    rest(); gwr_n = 0; din = 36'hFFFFFFFFF; tick("R1");
    rest(); sel_on(); cs3_n = 1; pstb_n = 0; addr = 0; tick("R1");
    rest(); sel_on(); pstb_n = 0; addr = 0; tick("R1");
    rest(); tick("R1");
    rest(); tick("R1");
    // R9: continuation write at burst address with chip enables off
    rest(); cs1_n = 1; cs2 = 0; adv_n = 0; burst = 7; gwr_n = 0; din = 36'h0000ABCDE; tick("R9");
    rest(); sel_on(); cstb_n = 0; addr = 7; tick("R9");
    rest(); tick("R9");
    rest(); tick("R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule